// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic update of a word in a single-ported synchronous memory. A request brings a base address, a signed 16-bit displacement, a size code, an operation byte, the value of the source register and the value of register zero. The unit takes the memory port and reads the addressed word. It forms the new value and writes it back in the next cycle. It then presents one response cycle that tells the register file which results to write.

The operation byte holds two things: the kind of update, and a low bit that asks for the previous memory contents to be returned. Exchange and compare-exchange must always have that bit set. Compare-exchange is the one operation that reports the previous contents through the register-zero result and not through the source-register result. Another master asks for the memory port on a request line. It is granted the port only while the unit is idle and no atomic request is arriving.

Top module: `amo_unit`

## Requirements
- R1: Without the return bit, operation byte 0x00 adds the source to memory, 0x40 ORs it in, 0x50 ANDs it in and 0xa0 XORs it in. A 64-bit request (size code 2'b11) updates the whole word.
- R2: When bit 0 of the operation byte is set on one of the four simple operations, the response asserts the source-register write with the memory value from before the update. When the bit is clear, the response writes neither register.
- R3: Operation byte 0xe1 stores the source value and returns the previous memory value through the source-register result.
- R4: Operation byte 0xf1 compares memory with register zero and stores the source value only when they are equal. The register-zero result always carries the previous memory value, and the source-register result is never written.
- R5: A 32-bit request (size code 2'b00) works on the half of the 64-bit word that byte-address bit 2 selects (1 = upper). The other half stays unchanged. The returned value is zero-extended to 64 bits, and the compare uses only the low 32 bits of register zero.
- R6: Size codes 2'b01 and 2'b10 (16 and 8 bits) give an error response and leave memory unchanged.
- R7: Any operation byte other than the ten listed in R1 to R4 (the four simple bytes with bit 0 clear or set, plus 0xe1 and 0xf1) gives an error response and leaves memory unchanged. This includes 0xe0 and 0xf0.
- R8: A 64-bit request whose byte address is not a multiple of 8, or a 32-bit request whose byte address is not a multiple of 4, gives an error response and leaves memory unchanged.
- R9: The byte address is the base plus the sign-extended 16-bit displacement.
- R10: While an atomic sequence is in progress, the other master is never granted the port. With the unit idle and no request valid, a request from the other master is granted in the same cycle.
- R11: A valid request reads in the cycle after it is accepted and writes the same word in the cycle after the read. Its response follows one cycle later. An error response comes in the cycle right after acceptance.
- R12: After reset the unit is ready, has no response valid, does not access memory and grants nothing. Every response lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Atomic request present; taken when req_ready is high |
| req_ready | output | 1 | Unit is idle and accepts a request |
| req_base | input | ADDR_W | Base byte address (destination register value) |
| req_ofs | input | 16 | Signed byte displacement |
| req_size | input | 2 | 00 = 32 bit, 01 = 16 bit, 10 = 8 bit, 11 = 64 bit |
| req_op | input | 8 | Operation byte with return bit in bit 0 |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | Register zero value |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request was rejected |
| rsp_src_we | output | 1 | Write rsp_src_val to the source register |
| rsp_src_val | output | 64 | Previous memory value for the source register |
| rsp_r0_we | output | 1 | Write rsp_r0_val to register zero |
| rsp_r0_val | output | 64 | Previous memory value for register zero |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | MEM_AW | Memory word index (byte address bits above 2) |
| mem_wdata | output | 64 | Write data |
| mem_wmask | output | 8 | Byte write enables |
| mem_rdata | input | 64 | Read data, one cycle after the read |
| ext_req | input | 1 | Other master asks for the memory port |
| ext_gnt | output | 1 | Other master owns the port this cycle |

## Verification
The hardest case to reach is the contest for the port: the other master must be asking at the same moment that an atomic request arrives, and its request must stay up through the whole locked read and write. The directed lock test holds ext_req high, launches a request and samples the grant in every cycle of the sequence. After that it drops the request and looks for the grant again. The 32-bit cases with a negative displacement reach the upper half of a word. They use values chosen so that a carry out of the lane, or a wrong half, would show in the untouched half.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {K_ADD, K_OR, K_AND, K_XOR, K_XCHG, K_CAS} amo_kind_e;
  typedef enum logic [1:0] {SZ_W = 2'b00, SZ_H = 2'b01, SZ_B = 2'b10, SZ_D = 2'b11} amo_size_e;
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_RSP} amo_state_e;

  typedef struct packed {
    logic      ok;
    amo_kind_e kind;
    logic      fetch;
  } amo_dec_t;

  // Split the operation byte into kind and return bit.
  function automatic amo_dec_t amo_decode_op(input logic [7:0] op);
    amo_dec_t d;
    d.ok    = 1'b1;
    d.fetch = op[0];
    d.kind  = K_ADD;
    case ({op[7:1], 1'b0})
      8'h00:   d.kind = K_ADD;
      8'h40:   d.kind = K_OR;
      8'h50:   d.kind = K_AND;
      8'ha0:   d.kind = K_XOR;
      8'he0: begin d.kind = K_XCHG; d.ok = op[0]; end
      8'hf0: begin d.kind = K_CAS;  d.ok = op[0]; end
      default: d.ok = 1'b0;
    endcase
    return d;
  endfunction

  // New memory value for every kind (compare-exchange gated outside).
  function automatic logic [63:0] amo_combine(input amo_kind_e k,
                                              input logic [63:0] old_v,
                                              input logic [63:0] src_v);
    case (k)
      K_ADD:   return old_v + src_v;
      K_OR:    return old_v | src_v;
      K_AND:   return old_v & src_v;
      K_XOR:   return old_v ^ src_v;
      default: return src_v;
    endcase
  endfunction
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [7:0]        op,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] base,
  input  logic [15:0]       ofs,
  output amo_dec_t          dec,
  output logic              wide,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              bad
);
  localparam int EXT_W = ADDR_W - 16;

  logic size_ok;
  logic misaligned;

  always_comb begin
    dec        = amo_decode_op(op);
    wide       = (size == SZ_D);
    size_ok    = (size == SZ_D) || (size == SZ_W);
    eff_addr   = base + {{EXT_W{ofs[15]}}, ofs};
    misaligned = wide ? (eff_addr[2:0] != 3'd0) : (eff_addr[1:0] != 2'd0);
    bad        = !dec.ok || !size_ok || misaligned;
  end
endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  amo_kind_e         kind,
  input  logic              wide,
  input  logic              lane,
  input  logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] r0,
  output logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W/8-1:0] wmask,
  output logic              do_write
);
  localparam int HALF  = DATA_W / 2;
  localparam int BYTES = DATA_W / 8;

  logic [HALF-1:0]   old_half;
  logic [DATA_W-1:0] src_eff;
  logic [DATA_W-1:0] new_val;
  logic              match;

  always_comb begin
    old_half = lane ? rdata[DATA_W-1:HALF] : rdata[HALF-1:0];
    old_val  = wide ? rdata : {{HALF{1'b0}}, old_half};
    src_eff  = wide ? src : {{HALF{1'b0}}, src[HALF-1:0]};
    match    = wide ? (rdata == r0) : (old_half == r0[HALF-1:0]);
    new_val  = amo_combine(kind, old_val, src_eff);
    do_write = (kind != K_CAS) || match;
    wdata    = wide ? new_val : {new_val[HALF-1:0], new_val[HALF-1:0]};
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign wmask[b] = wide || (lane == (b >= BYTES / 2));
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_bad,
  input  logic ext_req,
  output logic req_ready,
  output logic accept,
  output logic rd_phase,
  output logic wr_phase,
  output logic rsp_phase,
  output logic busy,
  output logic ext_gnt
);
  amo_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (req_valid) state <= req_bad ? S_RSP : S_RD;
        S_RD:    state <= S_WR;
        S_WR:    state <= S_RSP;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready = (state == S_IDLE);
    accept    = req_ready && req_valid;
    rd_phase  = (state == S_RD);
    wr_phase  = (state == S_WR);
    rsp_phase = (state == S_RSP);
    busy      = rd_phase || wr_phase;
    ext_gnt   = ext_req && req_ready && !req_valid;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [15:0]       req_ofs,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_op,
  input  logic [63:0]       req_src,
  input  logic [63:0]       req_r0,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              rsp_src_we,
  output logic [63:0]       rsp_src_val,
  output logic              rsp_r0_we,
  output logic [63:0]       rsp_r0_val,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_wmask,
  input  logic [63:0]       mem_rdata,
  input  logic              ext_req,
  output logic              ext_gnt
);
  localparam int WORD_LSB = 3;

  amo_dec_t          dec;
  logic              wide_in;
  logic [ADDR_W-1:0] eff_addr;
  logic              req_bad;
  logic              accept, rd_phase, wr_phase, rsp_phase, busy;

  amo_kind_e         kind_q;
  logic              fetch_q, wide_q, lane_q, err_q;
  logic              src_we_q, r0_we_q;
  logic [MEM_AW-1:0] waddr_q;
  logic [63:0]       src_q, r0_q, old_q;

  logic [63:0]       old_val;
  logic              do_write;

  amo_decode #(.ADDR_W(ADDR_W)) u_dec (
    .op(req_op), .size(req_size), .base(req_base), .ofs(req_ofs),
    .dec(dec), .wide(wide_in), .eff_addr(eff_addr), .bad(req_bad)
  );

  amo_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bad(req_bad),
    .ext_req(ext_req), .req_ready(req_ready), .accept(accept),
    .rd_phase(rd_phase), .wr_phase(wr_phase), .rsp_phase(rsp_phase),
    .busy(busy), .ext_gnt(ext_gnt)
  );

  amo_datapath #(.DATA_W(64)) u_dp (
    .kind(kind_q), .wide(wide_q), .lane(lane_q), .rdata(mem_rdata),
    .src(src_q), .r0(r0_q), .old_val(old_val), .wdata(mem_wdata),
    .wmask(mem_wmask), .do_write(do_write)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q   <= K_ADD;
      fetch_q  <= 1'b0;
      wide_q   <= 1'b0;
      lane_q   <= 1'b0;
      err_q    <= 1'b0;
      src_we_q <= 1'b0;
      r0_we_q  <= 1'b0;
      waddr_q  <= '0;
      src_q    <= '0;
      r0_q     <= '0;
      old_q    <= '0;
    end else if (accept) begin
      kind_q   <= dec.kind;
      fetch_q  <= dec.fetch;
      wide_q   <= wide_in;
      lane_q   <= eff_addr[2];
      err_q    <= req_bad;
      src_we_q <= 1'b0;
      r0_we_q  <= 1'b0;
      waddr_q  <= eff_addr[MEM_AW+WORD_LSB-1:WORD_LSB];
      src_q    <= req_src;
      r0_q     <= req_r0;
    end else if (wr_phase) begin
      old_q    <= old_val;
      src_we_q <= fetch_q && (kind_q != K_CAS);
      r0_we_q  <= (kind_q == K_CAS);
    end
  end

  always_comb begin
    mem_en      = rd_phase || (wr_phase && do_write);
    mem_we      = wr_phase && do_write;
    mem_addr    = waddr_q;
    rsp_valid   = rsp_phase;
    rsp_err     = rsp_phase && err_q;
    rsp_src_we  = rsp_phase && src_we_q;
    rsp_r0_we   = rsp_phase && r0_we_q;
    rsp_src_val = old_q;
    rsp_r0_val  = old_q;
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int MEM_AW = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ext_gnt,
  input logic              rd_phase,
  input logic              wr_phase,
  input logic              accept,
  input logic              req_bad,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              rsp_src_we,
  input logic              rsp_r0_we,
  input logic              mem_en,
  input logic [MEM_AW-1:0] mem_addr
);
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ext_gnt);
  // R11
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |=> (wr_phase && $stable(mem_addr)));
  // R11
  wr_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_phase |=> rsp_valid);
  // R6
  err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_bad) |=> (rsp_valid && rsp_err && !mem_en));
  // R7
  err_noresult_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!rsp_src_we && !rsp_r0_we));
  // R4
  cas_r0_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_r0_we |-> !rsp_src_we);
  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind amo_unit amo_unit_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ext_gnt(ext_gnt),
  .rd_phase(rd_phase), .wr_phase(wr_phase), .accept(accept),
  .req_bad(req_bad), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_src_we(rsp_src_we), .rsp_r0_we(rsp_r0_we), .mem_en(mem_en),
  .mem_addr(mem_addr)
);

// File: tb/tb_amo_unit.sv
`timescale 1ns/1ps
module tb_amo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_base = '0;
  logic [15:0] req_ofs = '0;
  logic [1:0]  req_size = '0;
  logic [7:0]  req_op = '0;
  logic [63:0] req_src = '0;
  logic [63:0] req_r0 = '0;
  logic        rsp_valid, rsp_err, rsp_src_we, rsp_r0_we;
  logic [63:0] rsp_src_val, rsp_r0_val;
  logic        mem_en, mem_we;
  logic [9:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_wmask;
  logic [63:0] mem_rdata = '0;
  logic        ext_req = 1'b0;
  logic        ext_gnt;

  int errors = 0;
  int checks = 0;
  logic [63:0] mem [0:1023];

  always #2.5 clk = ~clk;

  amo_unit dut (.*);

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we)
        for (int b = 0; b < 8; b++)
          if (mem_wmask[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      mem_rdata <= mem[mem_addr];
    end
  end

  typedef struct packed {
    logic [7:0]  op;
    logic [1:0]  sz;
    logic [15:0] base;
    logic [15:0] ofs;
    logic [15:0] word;
    logic [63:0] init;
    logic [63:0] src;
    logic [63:0] r0;
    logic [63:0] mem_exp;
    logic        err;
    logic        swe;
    logic [63:0] sval;
    logic        rwe;
    logic [63:0] rval;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R1 add, 64 bit, no return
    '{8'h00, 2'b11, 16'h0100, 16'h0000, 16'h0100, 64'h0000_0001_FFFF_FFFF, 64'h1, 64'h0,
      64'h0000_0002_0000_0000, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0},
    // R1 R2 or with return
    '{8'h41, 2'b11, 16'h0108, 16'h0000, 16'h0108, 64'h00F0_0000_0000_000F, 64'h0F00_0000_0000_00F0, 64'h0,
      64'h0FF0_0000_0000_00FF, 1'b0, 1'b1, 64'h00F0_0000_0000_000F, 1'b0, 64'h0},
    // R1 and
    '{8'h50, 2'b11, 16'h0110, 16'h0000, 16'h0110, 64'hFFFF_0000_FFFF_0000, 64'h0F0F_0F0F_0F0F_0F0F, 64'h0,
      64'h0F0F_0000_0F0F_0000, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0},
    // R1 R2 xor with return
    '{8'ha1, 2'b11, 16'h0118, 16'h0000, 16'h0118, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,
      64'h5555_5555_AAAA_AAAA, 1'b0, 1'b1, 64'hAAAA_AAAA_5555_5555, 1'b0, 64'h0},
    // R3 exchange
    '{8'he1, 2'b11, 16'h0120, 16'h0000, 16'h0120, 64'h1122_3344_5566_7788, 64'hDEAD_BEEF_0000_0001, 64'h0,
      64'hDEAD_BEEF_0000_0001, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 1'b0, 64'h0},
    // R4 compare-exchange, match
    '{8'hf1, 2'b11, 16'h0128, 16'h0000, 16'h0128, 64'h42, 64'h99, 64'h42,
      64'h99, 1'b0, 1'b0, 64'h0, 1'b1, 64'h42},
    // R4 compare-exchange, mismatch
    '{8'hf1, 2'b11, 16'h0130, 16'h0000, 16'h0130, 64'h43, 64'h99, 64'h42,
      64'h43, 1'b0, 1'b0, 64'h0, 1'b1, 64'h43},
    // R5 R9 32-bit add with return, upper half, negative displacement
    '{8'h01, 2'b00, 16'h0140, 16'hFFFC, 16'h0138, 64'h8000_0000_1234_5678, 64'hFFFF_FFFF_8000_0001, 64'h0,
      64'h0000_0001_1234_5678, 1'b0, 1'b1, 64'h0000_0000_8000_0000, 1'b0, 64'h0},
    // R5 32-bit exchange, lower half
    '{8'he1, 2'b00, 16'h0140, 16'h0000, 16'h0140, 64'hCAFE_BABE_0000_0007, 64'hFFFF_FFFF_1111_2222, 64'h0,
      64'hCAFE_BABE_1111_2222, 1'b0, 1'b1, 64'h7, 1'b0, 64'h0},
    // R5 32-bit compare-exchange ignores upper half of register zero
    '{8'hf1, 2'b00, 16'h0148, 16'h0000, 16'h0148, 64'h5555_5555_0000_00AB, 64'hCD, 64'hFFFF_FFFF_0000_00AB,
      64'h5555_5555_0000_00CD, 1'b0, 1'b0, 64'h0, 1'b1, 64'hAB},
    // R6 16-bit size rejected
    '{8'h00, 2'b01, 16'h0150, 16'h0000, 16'h0150, 64'h1, 64'h1, 64'h0,
      64'h1, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0},
    // R6 8-bit size rejected
    '{8'h00, 2'b10, 16'h0158, 16'h0000, 16'h0158, 64'h2, 64'h1, 64'h0,
      64'h2, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0},
    // R7 exchange without return bit
    '{8'he0, 2'b11, 16'h0160, 16'h0000, 16'h0160, 64'h3, 64'h9, 64'h0,
      64'h3, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0},
    // R7 unknown byte
    '{8'h10, 2'b11, 16'h0168, 16'h0000, 16'h0168, 64'h4, 64'h9, 64'h0,
      64'h4, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0},
    // R8 64-bit at offset 4
    '{8'h00, 2'b11, 16'h0170, 16'h0004, 16'h0170, 64'h77, 64'h1, 64'h0,
      64'h77, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0},
    // R8 32-bit at offset 2
    '{8'h00, 2'b00, 16'h0178, 16'h0002, 16'h0178, 64'h88, 64'h1, 64'h0,
      64'h88, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0},
    // R9 positive displacement
    '{8'h00, 2'b11, 16'h0100, 16'h0080, 16'h0180, 64'h5, 64'h7, 64'h0,
      64'hC, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0},
    // R5 32-bit and, lower half, upper untouched
    '{8'h50, 2'b00, 16'h0188, 16'h0000, 16'h0188, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_00FF_00FF, 64'h0,
      64'hFFFF_FFFF_00FF_00FF, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.err) begin
      if (v.sz == 2'b01 || v.sz == 2'b10) return "R6";
      if (v.op == 8'he0 || v.op == 8'h10) return "R7";
      return "R8";
    end
    if (v.op == 8'hf1) return "R4";
    if (v.op == 8'he1) return "R3";
    if (v.sz == 2'b00) return "R5";
    return "R1";
  endfunction

  task automatic run_vec(input vec_t v);
    int lat;
    string t;
    t = tag_of(v);
    mem[v.word[12:3]] = v.init;
    @(negedge clk);
    req_base  = {48'h0, v.base};
    req_ofs   = v.ofs;
    req_size  = v.sz;
    req_op    = v.op;
    req_src   = v.src;
    req_r0    = v.r0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 latency", 64'(lat), v.err ? 64'd1 : 64'd3);
    chk(t, {63'h0, rsp_err}, {63'h0, v.err});
    chk((v.ofs != 16'h0 && !v.err) ? "R9" : t, mem[v.word[12:3]], v.mem_exp);
    chk("R2 src write", {63'h0, rsp_src_we}, {63'h0, v.swe});
    if (v.swe) chk("R2 src value", rsp_src_val, v.sval);
    chk("R4 r0 write", {63'h0, rsp_r0_we}, {63'h0, v.rwe});
    if (v.rwe) chk("R4 r0 value", rsp_r0_val, v.rval);
    @(negedge clk);
    chk("R12 pulse", {63'h0, rsp_valid}, 64'h0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ready", {63'h0, req_ready}, 64'h1);
    chk("R12 rsp", {63'h0, rsp_valid}, 64'h0);
    chk("R12 mem_en", {63'h0, mem_en}, 64'h0);
    chk("R12 gnt", {63'h0, ext_gnt}, 64'h0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10 idle grant, then lock across a full sequence
    ext_req = 1'b1;
    @(negedge clk);
    chk("R10 idle grant", {63'h0, ext_gnt}, 64'h1);
    mem[10'h40] = 64'h10;
    req_base = 64'h200; req_ofs = 16'h0; req_size = 2'b11;
    req_op = 8'h00; req_src = 64'h1; req_r0 = 64'h0;
    req_valid = 1'b1;
    #0.5;
    chk("R10 request wins", {63'h0, ext_gnt}, 64'h0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      chk("R10 locked", {63'h0, ext_gnt}, 64'h0);
      @(negedge clk);
    end
    chk("R10 grant after", {63'h0, ext_gnt}, 64'h1);
    chk("R10 memory", mem[10'h40], 64'h11);
    ext_req = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule